// File: doc/BRIEF.md
# Phase-Accumulating Cosine Synthesizer Core

This block produces a sampled cosine waveform for a digital-to-analog converter. A 32-bit phase register advances by a programmable step every clock. The step is the tuning word, so the output frequency is step·fclk/2^32 for steps below 2^31. Larger steps wrap and appear as the mirrored image fclk·(1 − step/2^32). The top bits of the phase address a quarter-wave cosine table with quadrant folding. The table result leaves as a 14-bit offset-binary sample.

Software-side writes never touch the running state directly. Each write lands in a shadow copy of either the tuning word or the phase-zero control bit. A single-cycle update strobe then moves both shadow copies into the live registers on one edge. A tuning word of zero only freezes the phase. Returning the phase to zero takes the separate phase-zero control, which pins the phase register at zero while it is live. After reset the live phase-zero bit is set and its shadow copy is clear. The output therefore sits at the cos(0) code until the first update strobe.

Top module: `dds_shadow_core`

## Requirements
- R1: While reset is held, `phase_out` is 0 and `dac_code` is midscale 0x2000.
- R2: On every clock edge where the live phase-zero bit is 0, `phase_out` becomes its previous value plus the live tuning word, modulo 2^32. Steps of 2^31 or more wrap the same way.
- R3: A write with `wr_sel`=0 loads `wr_data` into the shadow tuning word. A write with `wr_sel`=1 loads `wr_data[0]` into the shadow phase-zero bit. Neither write changes the phase sequence until an update strobe.
- R4: An `io_update` pulse copies both shadow values into the live registers on the same edge. A write made in the same cycle as the strobe lands only in the shadow copy and is not carried over.
- R5: A live tuning word of zero holds `phase_out` at its present value and does not return it to zero.
- R6: While the live phase-zero bit is 1, `phase_out` is 0 from the next edge on.
- R7: After reset, `phase_out` stays 0 until the first `io_update`, even when the shadow registers have been written.
- R8: `dac_code` is offset binary and depends on `phase_out` as it stood two edges earlier. The lookup uses the top 14 phase bits. Phase 0 gives 0x3FFF, phase 0x8000_0000 gives 0x0001, and phases 0x4000_0000 and 0xC000_0000 give a code within 8 of 0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Shadow register write enable |
| wr_sel | input | 1 | Write target: 0 tuning word, 1 phase-zero bit |
| wr_data | input | 32 | Write data |
| io_update | input | 1 | Copies shadow values into the live registers |
| phase_out | output | 32 | Current phase register |
| dac_code | output | 14 | Offset-binary cosine sample |

## Verification
A change to the live registers takes effect on the edge of the update strobe itself. The phase register first uses the new step or phase-zero value on the following edge. The bench therefore records its reference phase one sample after the strobe and predicts the phase a fixed number of edges later. The cosine output trails the phase by two registers. The bench keeps a two-deep history of sampled phases and compares each output code with the phase taken two samples earlier. All sampling happens at the falling edge, half a period away from the registers.

// File: rtl/dds_pkg.sv
package dds_pkg;
   // target of a shadow register write
   typedef enum logic {
      SEL_STEP  = 1'b0,
      SEL_ZERO  = 1'b1
   } dds_sel_e;

   localparam real DDS_PI = 3.14159265358979323846;
endpackage

// File: rtl/dds_ctrl_regs.sv
module dds_ctrl_regs #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [ACC_W-1:0] wr_data,
   input  logic             io_update,
   output logic [ACC_W-1:0] ftw_buf,
   output logic             clr_buf,
   output logic [ACC_W-1:0] ftw_act,
   output logic             clr_act
);
   import dds_pkg::*;

   dds_sel_e sel;
   assign sel = dds_sel_e'(wr_sel);

   // shadow copies: written by the port, read by the update strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ftw_buf <= '0;
         clr_buf <= 1'b0;
      end else if (wr_en) begin
         if (sel == SEL_STEP) ftw_buf <= wr_data;
         else                 clr_buf <= wr_data[0];
      end
   end

   // live copies: phase-zero powers up set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ftw_act <= '0;
         clr_act <= 1'b1;
      end else if (io_update) begin
         ftw_act <= ftw_buf;
         clr_act <= clr_buf;
      end
   end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] step,
   input  logic             clear,
   output logic [ACC_W-1:0] phase
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     phase <= '0;
      else if (clear) phase <= '0;
      else            phase <= phase + step;
   end
endmodule

// File: rtl/dds_cos_lut.sv
module dds_cos_lut #(
   parameter int ADDR_W    = 14,
   parameter int LUT_ABITS = 12,
   parameter int DAC_W     = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [DAC_W-1:0]  code
);
   import dds_pkg::*;

   localparam int OFS_W = ADDR_W - 2;
   localparam int DEPTH = 1 << LUT_ABITS;
   localparam int AMP   = (1 << (DAC_W - 1)) - 1;
   localparam int MID   = 1 << (DAC_W - 1);
   localparam int MAG_W = DAC_W - 1;

   logic [1:0]           quad;
   logic [OFS_W-1:0]     ofs;
   logic [LUT_ABITS-1:0] idx;
   logic [LUT_ABITS-1:0] idx_fold;
   logic                 neg;
   logic [MAG_W-1:0]     rom [DEPTH];
   logic [MAG_W-1:0]     mag_q;
   logic                 neg_q;

   assign quad = addr[ADDR_W-1 -: 2];
   assign ofs  = addr[OFS_W-1:0];

   // full-resolution table or one indexed by the upper offset bits only
   generate
      if (LUT_ABITS == OFS_W) begin : g_full
         assign idx = ofs;
      end else begin : g_trunc
         assign idx = ofs[OFS_W-1 -: LUT_ABITS];
      end
   endgenerate

   // odd quadrants read the table backwards; quadrants 1 and 2 are negative
   assign idx_fold = quad[0] ? ~idx : idx;
   assign neg      = quad[0] ^ quad[1];

   // quarter-wave magnitudes sampled at half-step centres
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_rom
         localparam real ANG = (real'(g) + 0.5) * DDS_PI / (2.0 * real'(DEPTH));
         localparam int  VAL = $rtoi(real'(AMP) * $cos(ANG) + 0.5);
         assign rom[g] = VAL[MAG_W-1:0];
      end
   endgenerate

   // stage 1: table read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mag_q <= '0;
         neg_q <= 1'b0;
      end else begin
         mag_q <= rom[idx_fold];
         neg_q <= neg;
      end
   end

   // stage 2: sign applied around midscale
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     code <= DAC_W'(MID);
      else if (neg_q) code <= DAC_W'(MID) - {1'b0, mag_q};
      else            code <= DAC_W'(MID) + {1'b0, mag_q};
   end
endmodule

// File: rtl/dds_shadow_core.sv
module dds_shadow_core #(
   parameter int ACC_W     = 32,
   parameter int ADDR_W    = 14,
   parameter int LUT_ABITS = 12,
   parameter int DAC_W     = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [ACC_W-1:0] wr_data,
   input  logic             io_update,
   output logic [ACC_W-1:0] phase_out,
   output logic [DAC_W-1:0] dac_code
);
   initial begin
      assert (ADDR_W >= 3 && ADDR_W <= ACC_W)
         else $error("phase address width out of range");
      assert (LUT_ABITS >= 1 && LUT_ABITS <= ADDR_W - 2)
         else $error("table address width out of range");
      assert (DAC_W >= 3) else $error("sample width too small");
   end

   logic [ACC_W-1:0] ftw_buf;
   logic [ACC_W-1:0] ftw_act;
   logic             clr_buf;
   logic             clr_act;

   dds_ctrl_regs #(.ACC_W(ACC_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .io_update (io_update),
      .ftw_buf   (ftw_buf),
      .clr_buf   (clr_buf),
      .ftw_act   (ftw_act),
      .clr_act   (clr_act)
   );

   dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (ftw_act),
      .clear (clr_act),
      .phase (phase_out)
   );

   dds_cos_lut #(
      .ADDR_W    (ADDR_W),
      .LUT_ABITS (LUT_ABITS),
      .DAC_W     (DAC_W)
   ) u_cos (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (phase_out[ACC_W-1 -: ADDR_W]),
      .code  (dac_code)
   );
endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk #(
   parameter int ACC_W = 32,
   parameter int DAC_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             io_update,
   input logic [ACC_W-1:0] phase_out,
   input logic [DAC_W-1:0] dac_code,
   input logic [ACC_W-1:0] ftw_buf,
   input logic             clr_buf,
   input logic [ACC_W-1:0] ftw_act,
   input logic             clr_act
);
   localparam logic [DAC_W-1:0] FULL = {DAC_W{1'b1}};

   logic       seen_upd;
   logic [1:0] cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_upd <= 1'b0;
         cyc      <= '0;
      end else begin
         seen_upd <= seen_upd | io_update;
         if (cyc != 2'd3) cyc <= cyc + 2'd1;
      end
   end

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_act |=> phase_out == $past(phase_out) + $past(ftw_act));

   assert_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      io_update |=> (ftw_act == $past(ftw_buf)) && (clr_act == $past(clr_buf)));

   assert_hold_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !io_update |=> $stable(ftw_act) && $stable(clr_act));

   assert_zero_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_act |=> phase_out == '0);

   assert_powerup_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_upd |-> phase_out == '0);

   assert_full_scale_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && $past(phase_out, 2) == '0) |-> dac_code == FULL);
endmodule

bind dds_shadow_core dds_core_chk #(.ACC_W(ACC_W), .DAC_W(DAC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_update (io_update),
   .phase_out (phase_out),
   .dac_code  (dac_code),
   .ftw_buf   (ftw_buf),
   .clr_buf   (clr_buf),
   .ftw_act   (ftw_act),
   .clr_act   (clr_act)
);

// File: tb/sim_dds_shadow_core.sv
module sim_dds_shadow_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        io_update = 1'b0;
   logic [31:0] phase_out;
   logic [13:0] dac_code;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dds_shadow_core u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .io_update (io_update),
      .phase_out (phase_out),
      .dac_code  (dac_code)
   );

   // step vectors: tuning word, edges to run, expected phase offset after them
   localparam int NV = 6;
   localparam logic [31:0] V_FTW [NV] = '{32'h0000_0001, 32'h1234_5678, 32'h8000_0000,
                                          32'hFFFF_FFFF, 32'hC000_0000, 32'h7FFF_FFFF};
   localparam int          V_N   [NV] = '{5, 7, 3, 4, 5, 2};
   localparam logic [31:0] V_EXP [NV] = '{32'h0000_0005, 32'h7F6E_5D48, 32'h8000_0000,
                                          32'hFFFF_FFFC, 32'hC000_0000, 32'hFFFF_FFFE};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_near_mid(input string req, input logic [13:0] act);
      total++;
      if (act < 14'd8184 || act > 14'd8200) begin
         bad++;
         $display("FAIL %s actual=%h expected=2000+-8", req, act);
      end
   endtask

   task automatic nedge();
      @(negedge clk);
   endtask

   task automatic write_reg(input logic sel, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      nedge();
      wr_en = 1'b0;
   endtask

   task automatic strobe();
      io_update = 1'b1;
      nedge();
      io_update = 1'b0;
   endtask

   function automatic logic [13:0] cos_expect(input logic [31:0] ph, output bit near_mid);
      near_mid = 1'b0;
      if (ph == 32'h0000_0000) return 14'h3FFF;
      if (ph == 32'h8000_0000) return 14'h0001;
      near_mid = 1'b1;
      return 14'h2000;
   endfunction

   initial begin
      #(20 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] p0;
      logic [31:0] hist0;
      logic [31:0] hist1;
      logic [13:0] e;
      bit nm;

      // R1 reset state
      nedge(); nedge();
      chk("R1 phase in reset", phase_out, 32'h0);
      chk("R1 dac in reset", {18'h0, dac_code}, 32'h2000);
      rst_n = 1'b1;

      // R7 shadow writes before any update leave the phase at zero
      write_reg(1'b0, 32'h0100_0000);
      write_reg(1'b1, 32'h0);
      for (int i = 0; i < 5; i++) begin
         nedge();
         chk("R7 phase held before first update", phase_out, 32'h0);
      end
      chk("R8 cos(0) code at powerup", {18'h0, dac_code}, 32'h3FFF);

      // R4/R7 first strobe releases the clear one edge later
      strobe();
      chk("R4 phase on strobe edge", phase_out, 32'h0);
      nedge();
      chk("R7 first advance after update", phase_out, 32'h0100_0000);

      // R2 table of step vectors
      for (int v = 0; v < NV; v++) begin
         write_reg(1'b0, V_FTW[v]);
         strobe();
         p0 = phase_out;
         for (int k = 0; k < V_N[v]; k++) nedge();
         chk($sformatf("R2 vector %0d", v), phase_out - p0, V_EXP[v]);
      end

      // R5 zero step holds phase
      write_reg(1'b0, 32'h0000_1000);
      strobe();
      nedge(); nedge();
      write_reg(1'b0, 32'h0);
      strobe();
      p0 = phase_out;
      for (int k = 0; k < 10; k++) nedge();
      chk("R5 zero step holds phase", phase_out, p0);
      total++;
      if (p0 == 32'h0) begin
         bad++;
         $display("FAIL R5 phase returned to zero actual=%h expected=nonzero", p0);
      end

      // R4 write in the strobe cycle stays in the shadow copy
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_0010; io_update = 1'b1;
      nedge();
      wr_en = 1'b0; io_update = 1'b0;
      p0 = phase_out;
      nedge(); nedge(); nedge();
      chk("R4 same-cycle write not carried", phase_out, p0);
      strobe();
      p0 = phase_out;
      nedge(); nedge(); nedge();
      chk("R4 later strobe carries write", phase_out - p0, 32'h30);

      // R3 shadow phase-zero write alone does not stop advance
      write_reg(1'b1, 32'h1);
      p0 = phase_out;
      nedge(); nedge(); nedge();
      chk("R3 shadow zero bit no effect", phase_out - p0, 32'h30);

      // R6 strobe makes the zero bit live
      strobe();
      nedge();
      chk("R6 phase forced to zero", phase_out, 32'h0);
      nedge(); nedge(); nedge();
      chk("R6 phase stays zero", phase_out, 32'h0);
      chk("R8 cleared phase gives full scale", {18'h0, dac_code}, 32'h3FFF);

      // R8 quarter-turn stepping, output compared with phase two samples back
      write_reg(1'b0, 32'h4000_0000);
      write_reg(1'b1, 32'h0);
      strobe();
      chk("R6 zero held on strobe edge", phase_out, 32'h0);
      hist1 = phase_out;
      nedge();
      hist0 = phase_out;
      chk("R2 quarter step", hist0, 32'h4000_0000);
      for (int k = 0; k < 8; k++) begin
         nedge();
         e = cos_expect(hist1, nm);
         if (nm) chk_near_mid($sformatf("R8 quarter phase %h", hist1), dac_code);
         else    chk($sformatf("R8 phase %h", hist1), {18'h0, dac_code}, {18'h0, e});
         hist1 = hist0;
         hist0 = phase_out;
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule